// File: doc/BRIEF.md
# Output Fault and Power-Good Supervisor

This block watches one regulated output of a synchronous buck controller and decides, cycle by cycle, whether that converter may switch, whether its power-good line is released, and whether the chip has to shut down. It receives digitised comparator flags for the sensed output: above 120 %, below 90 %, above 110 % and below 75 % of set point. It also takes a flag that says soft-start has reached its 1.5 V level, two supply-threshold flags that form an under-voltage lockout with hysteresis, two temperature flags and the enable input.

Its outputs are the gated high-side and low-side drive requests, an open-drain pull-down for power-good, an allow flag for light-load hysteretic operation, an active flag that lets the soft-start ramp run, and a latched-shutdown flag. Over-voltage acts as a soft crowbar that releases by itself. Under-voltage latches the chip off, but only once soft-start has completed. Every output comparator flag passes through a digital noise filter, whose length in clocks is a parameter, before it has any effect.

Top module: `pwr_fault_supervisor`

## Requirements
- R1: Supply lockout has hysteresis. The block becomes active only after `vcc_rise_i` has been seen. It turns inactive when `vcc_fall_i` is seen. While both flags are low it keeps its previous state. Going inactive is a full power-on reset of the sequence and also clears a latched fault.
- R2: While `ss_ready_i` is low, `hyst_ok_o` stays 0 and `pg_pull_o` stays 1. `hyst_ok_o` is 1 only when the block is active and `ss_ready_i` is high.
- R3: Once the block is active and soft-start has completed, `pg_pull_o` is 1 exactly while the filtered below-90 % flag or the filtered above-110 % flag is set.
- R4: An output comparator flag acts only after it has stayed high for `FILT_CYC` consecutive clocks (`FILT_CYC` ≥ 2). A shorter pulse has no effect at any output. The count restarts whenever the flag drops. With the flag held high from the first sampling edge, a drive output responds on edge `FILT_CYC`+1.
- R5: While the block is active and the filtered above-120 % flag is set, `ls_drive_o` is 1 and `hs_drive_o` is 0. Two clocks after the flag drops, normal drive resumes. No latch is involved.
- R6: A filtered below-75 % flag while `ss_ready_i` is low is ignored. The same flag while `ss_ready_i` is high sets `latched_o`.
- R7: While latched, `hs_drive_o` and `ls_drive_o` are 0 and `pg_pull_o` is 1. This holds whatever the requests and comparator flags are doing, and the latch persists.
- R8: A latched fault is cleared by driving `en_i` low or by the supply falling. When `en_i` is high again, the block restarts through the inactive state.
- R9: `temp_hot_i` stops an active block. A restart is allowed only after `temp_cool_i` has been seen.
- R10: When the block is active with no over-voltage, `ls_drive_o` follows `ls_req_i` and `hs_drive_o` follows `hs_req_i` unless `ls_req_i` is also high. The two drive outputs are never 1 together.
- R11: After reset, `pg_pull_o` is 1 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable; a low level clears a latched fault |
| vcc_rise_i | input | 1 | Supply above the rising lockout threshold |
| vcc_fall_i | input | 1 | Supply below the falling lockout threshold |
| temp_hot_i | input | 1 | Die above the shutdown temperature |
| temp_cool_i | input | 1 | Die below the restart temperature |
| ss_ready_i | input | 1 | Soft-start has reached its completion level |
| cmp_ov_i | input | 1 | Output above 120 % of set point |
| cmp_hi_i | input | 1 | Output above 110 % of set point |
| cmp_lo_i | input | 1 | Output below 90 % of set point |
| cmp_uv_i | input | 1 | Output below 75 % of set point |
| hs_req_i | input | 1 | High-side on request from the modulator |
| ls_req_i | input | 1 | Low-side on request from the modulator |
| hs_drive_o | output | 1 | Gated high-side drive |
| ls_drive_o | output | 1 | Gated low-side drive |
| pg_pull_o | output | 1 | 1 = pull the open-drain power-good line low |
| hyst_ok_o | output | 1 | Light-load hysteretic mode allowed |
| active_o | output | 1 | Converter running; soft-start may ramp |
| latched_o | output | 1 | Latched under-voltage shutdown |

## Verification
The bench sweeps pulse lengths from one clock up to past the filter length on the over-voltage and above-110 % flags. This catches an off-by-one filter, which would let a pulse one clock too short reach the drivers or power-good, or would swallow a pulse of exactly the filter length. It drives under-voltage both before and after soft-start completes, so a latch that ignores the soft-start gate would shut the chip down during start-up. It also checks that the crowbar releases by itself rather than sticking. The lockout and temperature flags are pulsed and then dropped, so a design without hysteresis would restart, or fail to hold, while both flags read low. The latch is cleared by the enable input and then by the supply, and a design that ignored either path would stay off.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;

  typedef enum logic [1:0] {
    SUP_IDLE  = 2'd0,
    SUP_RUN   = 2'd1,
    SUP_TRIP  = 2'd2
  } sup_state_e;

  localparam int FLAG_OV  = 0;
  localparam int FLAG_HI  = 1;
  localparam int FLAG_LO  = 2;
  localparam int FLAG_UV  = 3;
  localparam int NUM_CMP  = 4;

endpackage

// File: rtl/pwr_deglitch.sv
module pwr_deglitch #(
  parameter int NUM      = 4,
  parameter int FILT_CYC = 250
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NUM-1:0] raw_i,
  output logic [NUM-1:0] flt_o
);

  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] CNT_TOP  = CW'(FILT_CYC);
  localparam logic [CW-1:0] CNT_FIRE = CW'(FILT_CYC - 1);

  for (genvar g = 0; g < NUM; g++) begin : g_lane
    logic [CW-1:0] cnt_q;
    logic          hit_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q <= '0;
        hit_q <= 1'b0;
      end else if (!raw_i[g]) begin
        cnt_q <= '0;
        hit_q <= 1'b0;
      end else begin
        if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
        hit_q <= (cnt_q >= CNT_FIRE);
      end
    end

    assign flt_o[g] = hit_q;
  end

endmodule

// File: rtl/pwr_sequencer.sv
module pwr_sequencer
  import pwr_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic       vcc_rise_i,
  input  logic       vcc_fall_i,
  input  logic       temp_hot_i,
  input  logic       temp_cool_i,
  input  logic       ss_ready_i,
  input  logic       uv_flt_i,
  output sup_state_e state_o
);

  logic       vcc_ok_q;
  logic       too_hot_q;
  sup_state_e st_q, st_d;

  // supply lockout with hysteresis: falling threshold wins
  always_ff @(posedge clk) begin
    if (rst)             vcc_ok_q <= 1'b0;
    else if (vcc_fall_i) vcc_ok_q <= 1'b0;
    else if (vcc_rise_i) vcc_ok_q <= 1'b1;
  end

  // thermal shutdown with hysteresis: hot flag wins
  always_ff @(posedge clk) begin
    if (rst)              too_hot_q <= 1'b0;
    else if (temp_hot_i)  too_hot_q <= 1'b1;
    else if (temp_cool_i) too_hot_q <= 1'b0;
  end

  always_comb begin
    st_d = st_q;
    if (!vcc_ok_q) begin
      st_d = SUP_IDLE;
    end else begin
      unique case (st_q)
        SUP_IDLE: if (en_i && !too_hot_q) st_d = SUP_RUN;
        SUP_RUN: begin
          if (!en_i || too_hot_q)        st_d = SUP_IDLE;
          else if (uv_flt_i && ss_ready_i) st_d = SUP_TRIP;
        end
        SUP_TRIP: if (!en_i) st_d = SUP_IDLE;
        default: st_d = SUP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= SUP_IDLE;
    else     st_q <= st_d;
  end

  assign state_o = st_q;

endmodule

// File: rtl/pwr_fault_supervisor.sv
module pwr_fault_supervisor
  import pwr_sup_pkg::*;
#(
  parameter int FILT_CYC = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic vcc_rise_i,
  input  logic vcc_fall_i,
  input  logic temp_hot_i,
  input  logic temp_cool_i,
  input  logic ss_ready_i,
  input  logic cmp_ov_i,
  input  logic cmp_hi_i,
  input  logic cmp_lo_i,
  input  logic cmp_uv_i,
  input  logic hs_req_i,
  input  logic ls_req_i,
  output logic hs_drive_o,
  output logic ls_drive_o,
  output logic pg_pull_o,
  output logic hyst_ok_o,
  output logic active_o,
  output logic latched_o
);

  logic [NUM_CMP-1:0] cmp_raw, cmp_flt;
  sup_state_e         state;
  logic               running;
  logic               pg_good;

  always_comb begin
    cmp_raw          = '0;
    cmp_raw[FLAG_OV] = cmp_ov_i;
    cmp_raw[FLAG_HI] = cmp_hi_i;
    cmp_raw[FLAG_LO] = cmp_lo_i;
    cmp_raw[FLAG_UV] = cmp_uv_i;
  end

  pwr_deglitch #(
    .NUM      (NUM_CMP),
    .FILT_CYC (FILT_CYC)
  ) u_filt (
    .clk   (clk),
    .rst   (rst),
    .raw_i (cmp_raw),
    .flt_o (cmp_flt)
  );

  pwr_sequencer u_seq (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en_i),
    .vcc_rise_i  (vcc_rise_i),
    .vcc_fall_i  (vcc_fall_i),
    .temp_hot_i  (temp_hot_i),
    .temp_cool_i (temp_cool_i),
    .ss_ready_i  (ss_ready_i),
    .uv_flt_i    (cmp_flt[FLAG_UV]),
    .state_o     (state)
  );

  assign running = (state == SUP_RUN);
  assign pg_good = running && ss_ready_i && !cmp_flt[FLAG_LO] && !cmp_flt[FLAG_HI];

  // registered output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      hs_drive_o <= 1'b0;
      ls_drive_o <= 1'b0;
      pg_pull_o  <= 1'b1;
      hyst_ok_o  <= 1'b0;
    end else begin
      ls_drive_o <= running && (cmp_flt[FLAG_OV] || ls_req_i);
      hs_drive_o <= running && hs_req_i && !ls_req_i && !cmp_flt[FLAG_OV];
      pg_pull_o  <= !pg_good;
      hyst_ok_o  <= running && ss_ready_i;
    end
  end

  assign active_o  = running;
  assign latched_o = (state == SUP_TRIP);

endmodule

// File: rtl/pwr_fault_supervisor_chk.sv
module pwr_fault_supervisor_chk (
  input logic clk,
  input logic rst,
  input logic ss_ready_i,
  input logic hs_drive_o,
  input logic ls_drive_o,
  input logic pg_pull_o,
  input logic hyst_ok_o,
  input logic active_o,
  input logic latched_o
);

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
    !(hs_drive_o && ls_drive_o)); // R10

  AST_TRIP_QUIET: assert property (@(posedge clk) disable iff (rst)
    latched_o |=> (!hs_drive_o && !ls_drive_o && pg_pull_o)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!active_o && !latched_o) |=> (!hs_drive_o && !ls_drive_o)); // R1

  AST_PG_AFTER_SS: assert property (@(posedge clk) disable iff (rst)
    !pg_pull_o |-> hyst_ok_o); // R2

  AST_HYST_GATED: assert property (@(posedge clk) disable iff (rst)
    hyst_ok_o |-> $past(ss_ready_i)); // R2

  AST_ONE_STATE: assert property (@(posedge clk) disable iff (rst)
    !(active_o && latched_o)); // R8

endmodule

bind pwr_fault_supervisor pwr_fault_supervisor_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .ss_ready_i (ss_ready_i),
  .hs_drive_o (hs_drive_o),
  .ls_drive_o (ls_drive_o),
  .pg_pull_o  (pg_pull_o),
  .hyst_ok_o  (hyst_ok_o),
  .active_o   (active_o),
  .latched_o  (latched_o)
);

// File: tb/pwr_fault_supervisor_test.sv
`timescale 1ns/1ps
module pwr_fault_supervisor_test;

  localparam int FILT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_i = 0, vcc_rise_i = 0, vcc_fall_i = 0, temp_hot_i = 0, temp_cool_i = 0;
  logic ss_ready_i = 0, cmp_ov_i = 0, cmp_hi_i = 0, cmp_lo_i = 0, cmp_uv_i = 0;
  logic hs_req_i = 0, ls_req_i = 0;
  logic hs_drive_o, ls_drive_o, pg_pull_o, hyst_ok_o, active_o, latched_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pwr_fault_supervisor #(.FILT_CYC(FILT)) uut (
    .clk(clk), .rst(rst), .en_i(en_i), .vcc_rise_i(vcc_rise_i), .vcc_fall_i(vcc_fall_i),
    .temp_hot_i(temp_hot_i), .temp_cool_i(temp_cool_i), .ss_ready_i(ss_ready_i),
    .cmp_ov_i(cmp_ov_i), .cmp_hi_i(cmp_hi_i), .cmp_lo_i(cmp_lo_i), .cmp_uv_i(cmp_uv_i),
    .hs_req_i(hs_req_i), .ls_req_i(ls_req_i), .hs_drive_o(hs_drive_o), .ls_drive_o(ls_drive_o),
    .pg_pull_o(pg_pull_o), .hyst_ok_o(hyst_ok_o), .active_o(active_o), .latched_o(latched_o)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string sig, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s actual=%0b expected=%0b", req, sig, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // pulse a flag for len clocks and report whether the watched output ever went high
  task automatic pulse_watch(input int which, input int len, output logic seen);
    seen = 1'b0;
    if (which == 0) cmp_ov_i = 1'b1; else cmp_hi_i = 1'b1;
    for (int k = 0; k < len; k++) begin
      tick(1);
      if (which == 0) seen |= ls_drive_o; else seen |= pg_pull_o;
    end
    cmp_ov_i = 1'b0;
    cmp_hi_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick(1);
      if (which == 0) seen |= ls_drive_o; else seen |= pg_pull_o;
    end
    tick(3);
  endtask

  initial begin
    logic seen;
    @(negedge clk);
    tick(3);
    rst = 1'b0;
    tick(1);
    // R11 reset state
    chk("R11", "pg_pull_o", pg_pull_o, 1'b1);
    chk("R11", "hs_drive_o", hs_drive_o, 1'b0);
    chk("R11", "ls_drive_o", ls_drive_o, 1'b0);
    chk("R11", "hyst_ok_o", hyst_ok_o, 1'b0);
    chk("R11", "active_o", active_o, 1'b0);
    chk("R11", "latched_o", latched_o, 1'b0);

    // R1 no start without rising flag; hold after a single pulse
    en_i = 1'b1;
    tick(5);
    chk("R1", "active_o", active_o, 1'b0);
    vcc_rise_i = 1'b1; tick(1); vcc_rise_i = 1'b0;
    tick(5);
    chk("R1", "active_o", active_o, 1'b1);
    // R2 before soft-start completes
    chk("R2", "hyst_ok_o", hyst_ok_o, 1'b0);
    chk("R2", "pg_pull_o", pg_pull_o, 1'b1);

    // R6 under-voltage during soft-start is ignored
    cmp_uv_i = 1'b1; tick(FILT + 5);
    chk("R6", "latched_o", latched_o, 1'b0);
    chk("R6", "active_o", active_o, 1'b1);
    cmp_uv_i = 1'b0; tick(3);

    ss_ready_i = 1'b1; tick(3);
    chk("R2", "hyst_ok_o", hyst_ok_o, 1'b1);
    chk("R3", "pg_pull_o", pg_pull_o, 1'b0);

    // R4 R3 pulse-length sweep on the above-110 flag
    for (int len = 1; len <= FILT + 2; len++) begin
      pulse_watch(1, len, seen);
      chk("R4", $sformatf("pg_pull_o len=%0d", len), seen, logic'(len >= FILT));
    end
    // R3 below-90 window
    cmp_lo_i = 1'b1; tick(FILT + 3);
    chk("R3", "pg_pull_o low90", pg_pull_o, 1'b1);
    cmp_lo_i = 1'b0; tick(3);
    chk("R3", "pg_pull_o released", pg_pull_o, 1'b0);

    // R10 request combinations
    for (int c = 0; c < 4; c++) begin
      hs_req_i = c[0]; ls_req_i = c[1];
      tick(2);
      chk("R10", $sformatf("hs_drive_o c=%0d", c), hs_drive_o, logic'(c[0] && !c[1]));
      chk("R10", $sformatf("ls_drive_o c=%0d", c), ls_drive_o, logic'(c[1]));
    end
    hs_req_i = 1'b0; ls_req_i = 1'b0; tick(2);

    // R4 R5 pulse-length sweep on the over-voltage flag
    for (int len = 1; len <= FILT + 2; len++) begin
      pulse_watch(0, len, seen);
      chk("R4", $sformatf("ls_drive_o len=%0d", len), seen, logic'(len >= FILT));
    end
    // R4 exact edge and R5 non-latching crowbar
    hs_req_i = 1'b1; tick(2);
    cmp_ov_i = 1'b1;
    tick(FILT);
    chk("R4", "ls_drive_o before edge", ls_drive_o, 1'b0);
    tick(1);
    chk("R5", "ls_drive_o crowbar", ls_drive_o, 1'b1);
    chk("R5", "hs_drive_o crowbar", hs_drive_o, 1'b0);
    cmp_ov_i = 1'b0; tick(2);
    chk("R5", "ls_drive_o release", ls_drive_o, 1'b0);
    chk("R5", "hs_drive_o release", hs_drive_o, 1'b1);

    // R6 R7 under-voltage after soft-start latches
    cmp_uv_i = 1'b1; tick(FILT + 4);
    chk("R6", "latched_o", latched_o, 1'b1);
    chk("R7", "hs_drive_o", hs_drive_o, 1'b0);
    chk("R7", "pg_pull_o", pg_pull_o, 1'b1);
    cmp_uv_i = 1'b0; cmp_ov_i = 1'b1; tick(FILT + 4);
    chk("R7", "latched_o holds", latched_o, 1'b1);
    chk("R7", "ls_drive_o", ls_drive_o, 1'b0);
    cmp_ov_i = 1'b0; hs_req_i = 1'b0; tick(2);

    // R8 clear by enable
    en_i = 1'b0; tick(3);
    chk("R8", "latched_o cleared", latched_o, 1'b0);
    chk("R8", "active_o off", active_o, 1'b0);
    en_i = 1'b1; tick(3);
    chk("R8", "active_o restart", active_o, 1'b1);

    // R8 R1 clear by supply fall, no restart until rising flag
    cmp_uv_i = 1'b1; tick(FILT + 4); cmp_uv_i = 1'b0;
    chk("R8", "latched_o again", latched_o, 1'b1);
    vcc_fall_i = 1'b1; tick(4); vcc_fall_i = 1'b0;
    chk("R8", "latched_o supply", latched_o, 1'b0);
    tick(4);
    chk("R1", "active_o held off", active_o, 1'b0);
    vcc_rise_i = 1'b1; tick(1); vcc_rise_i = 1'b0; tick(4);
    chk("R1", "active_o rerun", active_o, 1'b1);

    // R9 thermal shutdown with hysteresis
    temp_hot_i = 1'b1; tick(1); temp_hot_i = 1'b0; tick(4);
    chk("R9", "active_o hot", active_o, 1'b0);
    tick(4);
    chk("R9", "active_o still off", active_o, 1'b0);
    temp_cool_i = 1'b1; tick(1); temp_cool_i = 1'b0; tick(4);
    chk("R9", "active_o cooled", active_o, 1'b1);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      summary();
      $finish;
    end
  end

endmodule